// File: doc/BRIEF.md
# Interprocessor Interrupt Command Sequencer

This block turns a one-cycle request into the register traffic that makes a local interrupt controller send an interprocessor interrupt. It writes a two-word command register, the destination word first and then the command word, because writing the command word is what sends the message. It then reads the command word back on every cycle until its delivery-status bit is clear. A request may ask for one message of fixed, SMI or INIT type. It may also ask for the processor wake chain, which is an INIT message followed by two identical start-up messages, with fixed gaps between them.

The target is either an 8-bit destination ID or the "all processors except the sender" shorthand. The gaps between messages are measured in microseconds. The block counts them from a `tick` input, and a parameter (`TICKS_PER_US`) sets how many ticks make one microsecond. A wake request whose start-routine address cannot be expressed as a start-up vector is refused. The interrupt controller and the bus that carries the register accesses are outside this block.

Top module: `ipi_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `err`, `reg_wr` and `reg_rd` are all 0 after that edge.
- R2: One cycle after a request is accepted, the block writes the high command word (`reg_sel_high`=1). That word is `dest<<24` for a targeted message and zero for the shorthand. The low command word is written in the following cycle (`reg_sel_high`=0).
- R3: The low command word has the following fields. Bits 7:0 hold the vector: the requested vector for fixed messages, zero for SMI and INIT. Bits 10:8 hold the delivery mode: fixed=000, SMI=010, INIT=101, start-up=110. Bit 14 is always 1. Bits 19:18 are 11 for the shorthand and 00 otherwise. All other bits are 0.
- R4: In the cycle after the low-word write, `reg_rd` goes high, and it stays high on every cycle until the sampled `reg_rdata[12]` is 0. A message completes at that edge. `reg_wr` and `reg_rd` are never high together.
- R5: A wake request (`req_kind`=11) sends three messages: INIT, then start-up, then start-up. The two start-up messages are identical, and their vector is bits 19:12 of `req_start_addr`.
- R6: After the INIT message completes, the block waits `10*TICKS_PER_US` ticks before the next high-word write. After the first start-up message completes, it waits `200*TICKS_PER_US` ticks. The next message's high-word write appears in the cycle after the edge at which the last tick is sampled.
- R7: `busy` is high from the cycle after acceptance until the edge at which the last message completes. Requests presented while `busy` is high are ignored.
- R8: A wake request whose address is 1 MiB or above, or whose address is not 4 KiB aligned, is refused. `err` is high for exactly the next cycle, no register access is made, and `busy` stays low.
- R9: `err` is never high for two consecutive cycles, and it is never high after an accepted request.
- R10: Request kinds are encoded on `req_kind` as fixed=00, SMI=01, INIT=10 and wake=11. For the shorthand, only the all-ones shorthand field is sent, and `req_dest` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base tick, TICKS_PER_US per microsecond |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_kind | input | 2 | 00 fixed, 01 SMI, 10 INIT, 11 wake chain |
| req_all_excl | input | 1 | Use the all-but-self shorthand |
| req_dest | input | 8 | Destination ID |
| req_vector | input | 8 | Vector for fixed messages |
| req_start_addr | input | ADDR_W | Start-routine address for the wake chain |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | One-cycle pulse on a refused request |
| reg_wr | output | 1 | Command register write strobe |
| reg_rd | output | 1 | Command low-word read strobe |
| reg_sel_high | output | 1 | 1 selects the high word, 0 the low word |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Low-word read data, sampled while `reg_rd` is high |

## Verification
The results arrive on a fixed timeline after a request is sampled:
- The high-word write and `busy` appear one cycle after the sampling edge.
- The low-word write appears two cycles after.
- The polls run from the third cycle, and there are one more of them than the emulated acceptance latency.
- `err` appears one cycle after a refused request.
- Each gap lasts exactly as many cycles as it takes to see the programmed number of ticks.

A behavioural reference in the bench walks these steps at every rising edge. It compares all outputs at the following falling edge. Completion counts then confirm the number of low-word writes, the `busy` duration with a tick on every cycle, and the final start-up word.

// File: rtl/ipi_seq_pkg.sv
// Shared types and encodings for the interprocessor interrupt sequencer.
// Assumes a 32-bit command register split into a high (destination) word and
// a low (command) word whose delivery-status flag sits at bit 12.
package ipi_seq_pkg;

    localparam int WORD_W     = 32;
    localparam int ID_W       = 8;
    localparam int VEC_W      = 8;
    localparam int STATUS_BIT = 12;
    localparam int LEVEL_BIT  = 14;
    localparam int SHORT_LSB  = 18;
    localparam int PAGE_LSB   = 12;   // start-up vector = address >> 12
    localparam int LIMIT_LSB  = 20;   // start address must stay below 1 MiB

    typedef enum logic [1:0] {
        KIND_FIXED = 2'd0,
        KIND_SMI   = 2'd1,
        KIND_INIT  = 2'd2,
        KIND_WAKE  = 2'd3
    } ipi_kind_e;

    localparam logic [2:0] DM_FIXED = 3'b000;
    localparam logic [2:0] DM_SMI   = 3'b010;
    localparam logic [2:0] DM_INIT  = 3'b101;
    localparam logic [2:0] DM_START = 3'b110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HIGH,
        PH_LOW,
        PH_POLL,
        PH_GAP
    } ipi_phase_e;

    typedef struct packed {
        ipi_kind_e         kind;
        logic              all_excl;
        logic [ID_W-1:0]   dest;
        logic [VEC_W-1:0]  vector;
        logic [VEC_W-1:0]  page;
    } ipi_req_t;

    // Assemble the low command word from its fields.
    function automatic logic [WORD_W-1:0] pack_low(input logic [2:0] dm,
                                                   input logic [VEC_W-1:0] vec,
                                                   input logic all_excl);
        logic [WORD_W-1:0] w;
        w                         = '0;
        w[VEC_W-1:0]              = vec;
        w[10:8]                   = dm;
        w[LEVEL_BIT]              = 1'b1;
        w[SHORT_LSB+1:SHORT_LSB]  = all_excl ? 2'b11 : 2'b00;
        return w;
    endfunction

endpackage

// File: rtl/ipi_word_builder.sv
// Builds the high and low command words for the message at the current step.
// Purely combinational; assumes the request fields are held stable by the
// controller for the whole sequence.
module ipi_word_builder
    import ipi_seq_pkg::*;
(
    input  ipi_req_t           rq,
    input  logic [1:0]         step,
    output logic [WORD_W-1:0]  hi_word,
    output logic [WORD_W-1:0]  lo_word
);

    logic [2:0]        dm;
    logic [VEC_W-1:0]  vec;

    // Pick delivery mode and vector from the request kind and chain step.
    always_comb begin
        dm  = DM_FIXED;
        vec = '0;
        unique case (rq.kind)
            KIND_FIXED: begin dm = DM_FIXED; vec = rq.vector; end
            KIND_SMI:   begin dm = DM_SMI; end
            KIND_INIT:  begin dm = DM_INIT; end
            KIND_WAKE: begin
                if (step == 2'd0) begin
                    dm = DM_INIT;
                end else begin
                    dm  = DM_START;
                    vec = rq.page;
                end
            end
            default: dm = DM_FIXED;
        endcase
    end

    // Destination sits in the top byte; shorthand messages carry zero.
    always_comb begin
        hi_word = '0;
        if (!rq.all_excl) begin
            hi_word[WORD_W-1 -: ID_W] = rq.dest;
        end
    end

    assign lo_word = pack_low(dm, vec, rq.all_excl);

endmodule

// File: rtl/ipi_gap_timer.sv
// Counts time-base ticks while the controller sits in an inter-message gap.
// Assumes run stays high for the whole gap; the counter clears when it drops.
// expired is high in the cycle whose tick is the last one of the gap.
module ipi_gap_timer #(
    parameter int TICKS_PER_US = 4,
    parameter int SHORT_US     = 10,
    parameter int LONG_US      = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_long,
    input  logic tick,
    output logic expired
);

    localparam int SHORT_T = TICKS_PER_US * SHORT_US;
    localparam int LONG_T  = TICKS_PER_US * LONG_US;
    localparam int MAX_T   = (LONG_T > SHORT_T) ? LONG_T : SHORT_T;
    localparam int CNT_W   = $clog2(MAX_T + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_val;

    generate
        if (SHORT_T == LONG_T) begin : g_single
            assign last_val = CNT_W'(SHORT_T - 1);
        end else begin : g_dual
            assign last_val = sel_long ? CNT_W'(LONG_T - 1) : CNT_W'(SHORT_T - 1);
        end
    endgenerate

    // Tick counter, held at zero outside a gap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign expired = run && tick && (cnt == last_val);

endmodule

// File: rtl/ipi_seq_ctrl.sv
// Phase controller: accepts a request when idle, walks each message through
// high write, low write and status polling, and steps through the wake chain.
// Assumes the caller has already judged the request's address legality.
module ipi_seq_ctrl
    import ipi_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_ok,
    input  ipi_req_t    req_in,
    input  logic        status_busy,
    input  logic        gap_done,
    output ipi_phase_e  phase,
    output logic [1:0]  step,
    output ipi_req_t    rq_q,
    output logic        err_q,
    output logic        gap_run,
    output logic        gap_long
);

    localparam logic [1:0] LAST_WAKE_STEP = 2'd2;

    logic last_msg;

    assign last_msg = (rq_q.kind != KIND_WAKE) || (step == LAST_WAKE_STEP);
    assign gap_run  = (phase == PH_GAP);
    assign gap_long = (step == 2'd1);

    // Sequence state, latched request and refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            step  <= '0;
            rq_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        if (!req_ok) begin
                            err_q <= 1'b1;
                        end else begin
                            rq_q  <= req_in;
                            step  <= '0;
                            phase <= PH_HIGH;
                        end
                    end
                end
                PH_HIGH: phase <= PH_LOW;
                PH_LOW:  phase <= PH_POLL;
                PH_POLL: begin
                    if (!status_busy) begin
                        phase <= last_msg ? PH_IDLE : PH_GAP;
                    end
                end
                PH_GAP: begin
                    if (gap_done) begin
                        step  <= step + 2'd1;
                        phase <= PH_HIGH;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ipi_sequencer.sv
// Top of the interprocessor interrupt sequencer. Checks wake addresses,
// drives the command-register port from the controller phase, and times the
// gaps of the wake chain from the tick input.
// Assumes reg_rdata is valid combinationally in any cycle with reg_rd high.
module ipi_sequencer
    import ipi_seq_pkg::*;
#(
    parameter int TICKS_PER_US = 4,
    parameter int INIT_GAP_US  = 10,
    parameter int START_GAP_US = 200,
    parameter int ADDR_W       = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic                 req_all_excl,
    input  logic [ID_W-1:0]      req_dest,
    input  logic [VEC_W-1:0]     req_vector,
    input  logic [ADDR_W-1:0]    req_start_addr,
    output logic                 busy,
    output logic                 err,
    output logic                 reg_wr,
    output logic                 reg_rd,
    output logic                 reg_sel_high,
    output logic [WORD_W-1:0]    reg_wdata,
    input  logic [WORD_W-1:0]    reg_rdata
);

    ipi_req_t           req_in;
    ipi_req_t           rq_q;
    ipi_phase_e         phase;
    logic [1:0]         step;
    logic               req_ok;
    logic               addr_ok;
    logic               gap_run;
    logic               gap_long;
    logic               gap_done;
    logic               err_q;
    logic [WORD_W-1:0]  hi_word;
    logic [WORD_W-1:0]  lo_word;
    logic               unused_rdata;

    // Address legality: below the 1 MiB limit and on a 4 KiB page boundary.
    assign addr_ok = ((req_start_addr >> LIMIT_LSB) == '0) &&
                     (req_start_addr[PAGE_LSB-1:0] == '0);
    assign req_ok  = (ipi_kind_e'(req_kind) != KIND_WAKE) || addr_ok;

    // Request fields as the controller will latch them.
    always_comb begin
        req_in.kind     = ipi_kind_e'(req_kind);
        req_in.all_excl = req_all_excl;
        req_in.dest     = req_dest;
        req_in.vector   = req_vector;
        req_in.page     = req_start_addr[PAGE_LSB +: VEC_W];
    end

    ipi_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ok      (req_ok),
        .req_in      (req_in),
        .status_busy (reg_rdata[STATUS_BIT]),
        .gap_done    (gap_done),
        .phase       (phase),
        .step        (step),
        .rq_q        (rq_q),
        .err_q       (err_q),
        .gap_run     (gap_run),
        .gap_long    (gap_long)
    );

    ipi_word_builder u_words (
        .rq      (rq_q),
        .step    (step),
        .hi_word (hi_word),
        .lo_word (lo_word)
    );

    ipi_gap_timer #(
        .TICKS_PER_US (TICKS_PER_US),
        .SHORT_US     (INIT_GAP_US),
        .LONG_US      (START_GAP_US)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gap_run),
        .sel_long (gap_long),
        .tick     (tick),
        .expired  (gap_done)
    );

    // Register-port drive derived from the current phase.
    always_comb begin
        reg_wr       = (phase == PH_HIGH) || (phase == PH_LOW);
        reg_rd       = (phase == PH_POLL);
        reg_sel_high = (phase == PH_HIGH);
        reg_wdata    = '0;
        if (phase == PH_HIGH) reg_wdata = hi_word;
        if (phase == PH_LOW)  reg_wdata = lo_word;
    end

    assign busy = (phase != PH_IDLE);
    assign err  = err_q;

    assign unused_rdata = ^{reg_rdata[WORD_W-1:STATUS_BIT+1], reg_rdata[STATUS_BIT-1:0]};

endmodule

// File: rtl/ipi_sequencer_chk.sv
// Port-level protocol checker for ipi_sequencer, attached by bind.
module ipi_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        err,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic        reg_sel_high,
    input logic [31:0] reg_wdata,
    input logic        poll_status
);

    AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd)); // R4

    AST_LOW_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel_high) |=> (reg_wr && !reg_sel_high)); // R2

    AST_LEVEL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel_high) |-> reg_wdata[14]); // R3

    AST_POLL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel_high) |=> reg_rd); // R4

    AST_KEEP_POLLING: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && poll_status) |=> reg_rd); // R4

    AST_ACCESS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> busy); // R7

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !reg_wr && !reg_rd)); // R8

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R9

endmodule

bind ipi_sequencer ipi_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .err          (err),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_sel_high (reg_sel_high),
    .reg_wdata    (reg_wdata),
    .poll_status  (reg_rdata[12])
);

// File: tb/sim_ipi_sequencer.sv
`timescale 1ns/1ps
module sim_ipi_sequencer;

    localparam int TPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_all_excl = 1'b0;
    logic [7:0]  req_dest = '0;
    logic [7:0]  req_vector = '0;
    logic [31:0] req_start_addr = '0;
    logic        busy, err, reg_wr, reg_rd, reg_sel_high;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    ipi_sequencer #(.TICKS_PER_US(TPU)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
        .req_kind(req_kind), .req_all_excl(req_all_excl), .req_dest(req_dest),
        .req_vector(req_vector), .req_start_addr(req_start_addr),
        .busy(busy), .err(err), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel_high(reg_sel_high), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- emulated interrupt controller ----------------
    int          lat = 0;
    int          pend = 0;
    logic [31:0] lo_q = '0;
    int          n_lo = 0;

    assign reg_rdata = {lo_q[31:13], (pend != 0), lo_q[11:0]};

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 0;
            lo_q <= '0;
        end else if (reg_wr && !reg_sel_high) begin
            lo_q <= reg_wdata;
            pend <= lat;
            n_lo <= n_lo + 1;
        end else if (reg_rd && pend != 0) begin
            pend <= pend - 1;
        end
    end

    // ---------------- tick source ----------------
    int tdiv = 1;
    int tcnt = 0;
    always @(negedge clk) begin
        tick <= ((tcnt % tdiv) == 0);
        tcnt <= tcnt + 1;
    end

    // ---------------- reference model ----------------
    bit          exp_busy = 0, exp_err = 0, exp_wr = 0, exp_rd = 0, exp_high = 0;
    logic [31:0] exp_wdata = '0;

    function automatic logic [31:0] lo_word(input int mode, input int vec, input bit ax);
        logic [31:0] r;
        r = '0;
        r[7:0]   = vec[7:0];
        r[10:8]  = mode[2:0];
        r[14]    = 1'b1;
        r[19:18] = ax ? 2'b11 : 2'b00;
        return r;
    endfunction

    initial begin : model
        forever begin
            @(posedge clk);
            exp_err = 0; exp_busy = 0; exp_wr = 0; exp_rd = 0; exp_high = 0; exp_wdata = '0;
            if (!rst_n) continue;
            if (req_valid) begin
                int k, d, v, nmsg;
                bit ax;
                logic [31:0] a;
                k = req_kind; ax = req_all_excl; d = req_dest; v = req_vector; a = req_start_addr;
                if (k == 3 && (a >= 32'h0010_0000 || a[11:0] != 0)) begin
                    exp_err = 1;
                    continue;
                end
                nmsg = (k == 3) ? 3 : 1;
                for (int m = 0; m < nmsg; m++) begin
                    int mode, vec, tgt, n;
                    case (k)
                        0: begin mode = 0; vec = v; end
                        1: begin mode = 2; vec = 0; end
                        2: begin mode = 5; vec = 0; end
                        default: begin
                            mode = (m == 0) ? 5 : 6;
                            vec  = (m == 0) ? 0 : int'(a[19:12]);
                        end
                    endcase
                    exp_busy = 1; exp_wr = 1; exp_rd = 0; exp_high = 1;
                    exp_wdata = ax ? 32'h0 : (32'(d) << 24);
                    @(posedge clk);
                    exp_high = 0; exp_wdata = lo_word(mode, vec, ax);
                    @(posedge clk);
                    exp_wr = 0; exp_rd = 1; exp_wdata = '0;
                    repeat (lat + 1) @(posedge clk);
                    exp_rd = 0;
                    if (m < nmsg - 1) begin
                        tgt = ((m == 0) ? 10 : 200) * TPU;
                        n = 0;
                        while (n < tgt) begin
                            @(posedge clk);
                            if (tick) n++;
                        end
                    end else begin
                        exp_busy = 0;
                    end
                end
            end
        end
    end

    // ---------------- comparator ----------------
    bit cmp_on = 0;
    int busy_cyc = 0;
    int err_cyc = 0;
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            check("R7 busy", busy, exp_busy);
            check("R8 err", err, exp_err);
            check("R2 reg_wr", reg_wr, exp_wr);
            check("R4 reg_rd", reg_rd, exp_rd);
            if (exp_wr) begin
                check("R2 reg_sel_high", reg_sel_high, exp_high);
                check(exp_high ? "R2 high word" : "R3 low word", reg_wdata, exp_wdata);
            end
            if (busy) busy_cyc++;
            if (err) err_cyc++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_req(input int kind, input bit ax, input int dest, input int vec,
                           input logic [31:0] addr, input int latv, input int tdv,
                           input bit poke, input int exp_lo, input int exp_busy_len,
                           input int exp_err_len, input string tag);
        int base, k;
        lat = latv; tdiv = tdv;
        @(negedge clk);
        base = n_lo; busy_cyc = 0; err_cyc = 0;
        req_valid = 1; req_kind = kind[1:0]; req_all_excl = ax;
        req_dest = dest[7:0]; req_vector = vec[7:0]; req_start_addr = addr;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            req_valid = poke && (k == 6 || k == 60);
            if (req_valid) begin
                req_kind = 2'd0; req_dest = 8'hEE; req_vector = 8'h99;
            end
        end while (exp_busy || k < 3);
        req_valid = 0;
        repeat (3) @(negedge clk);
        check({tag, " low-word writes"}, n_lo - base, exp_lo);
        if (exp_busy_len >= 0) check({tag, " busy cycles"}, busy_cyc, exp_busy_len);
        check({tag, " err cycles"}, err_cyc, exp_err_len);
    endtask

    initial begin : stim
        repeat (4) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 err in reset", err, 0);
        check("R1 reg_wr in reset", reg_wr, 0);
        check("R1 reg_rd in reset", reg_rd, 0);
        cmp_on = 1;
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3 fixed message to a targeted ID, two-poll latency
        run_req(0, 0, 'h5A, 'h33, 0, 2, 1, 0, 1, 5, 0, "R3 fixed");
        check("R3 fixed word", lo_q, 32'h0000_4033);
        // R10 SMI with shorthand: dest and vector have no effect
        run_req(1, 1, 'hAB, 'h77, 0, 0, 1, 0, 1, 3, 0, "R10 smi shorthand");
        check("R10 smi word", lo_q, 32'h000C_4200);
        // R3 INIT to top ID
        run_req(2, 0, 'hFF, 'h11, 0, 1, 1, 0, 1, 4, 0, "R3 init");
        check("R3 init word", lo_q, 32'h0000_4500);
        // R5 R6 wake chain, tick every cycle, pokes while busy (R7)
        run_req(3, 0, 'h12, 0, 32'h0009_A000, 3, 1, 1, 3, 3*6 + 10*TPU + 200*TPU, 0, "R6 wake");
        check("R5 final start-up word", lo_q, 32'h0000_469A);
        // R6 wake chain with sparse ticks, shorthand, zero latency
        run_req(3, 1, 'h44, 0, 32'h0000_1000, 0, 3, 1, 3, -1, 0, "R5 wake shorthand");
        check("R5 start-up shorthand word", lo_q, 32'h000C_4601);
        // R8 refused: address at 1 MiB, and misaligned
        run_req(3, 0, 'h01, 0, 32'h0010_0000, 0, 1, 0, 0, 0, 1, "R8 too high");
        run_req(3, 0, 'h01, 0, 32'h0009_A010, 0, 1, 0, 0, 0, 1, "R8 misaligned");
        // R9 highest legal page accepted, no error
        run_req(3, 0, 'h02, 0, 32'h000F_F000, 1, 1, 0, 3, 3*4 + 10*TPU + 200*TPU, 0, "R9 top page");
        check("R5 top page word", lo_q, 32'h0000_46FF);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", wd);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule